// File: doc/BRIEF.md
# Hierarchical Sensing Power Sequencer

This block decides how much of an always-on acoustic sensing chain is powered at any moment. At rest only the threshold detector and its preamplifier are on. When the detector reports sound of any kind, the block powers the feature-extraction bands and hands control to a hardware classifier. The block raises a wake request to the host processor only when the classifier reports speech. A free-running context timer also wakes the host at a fixed interval so that it can look for a change in the background noise and retrain. Once the host acknowledges, the chain drops back to detect-only operation.

The host programs four settings: a per-band enable mask, a gain code for the bands, a gain code for the detector preamplifier, and an idle limit. Each gain code drives four amplifier stages as a thermometer. A band that is masked off, or any band while the block is in detect mode, has all of its stages off.

The classifier result enters through a valid/ready pair. `cls_ready_o` is high only in classify mode. A result is taken in the cycle where valid and ready are both high. A valid presented while ready is low is dropped and never held over, because a stale decision has no meaning after the chain has powered down. `tick_i` is a one-cycle frame strobe, and every time limit counts these strobes.

Top module: `sense_power_seq`

## Requirements
- R1: After reset the block is in detect mode (`mode_o` = 0), all band enables and band stage enables are low, no wake is pending, `cls_ready_o` is low, the mask is all ones, both gain codes are 2, and the idle limit is 4.
- R2: Modes are encoded 0 = detect, 1 = classify, 2 = host. From detect, `activity_i` high at a clock edge moves the block to classify. `band_en_o` equals the mask in classify and host modes and is zero in detect mode.
- R3: `cls_ready_o` is high exactly in classify mode. A result is taken only when `cls_valid_i` and `cls_ready_o` are both high. A valid in any other mode has no effect on mode or wake outputs.
- R4: A taken result with `cls_speech_i` = 1 sets wake cause bit 0 and `host_wake_o` and enters host mode at the next edge. A taken result with `cls_speech_i` = 0 leaves the block in classify mode with no wake.
- R5: Gain code g (0..3, meaning 20..80 dB) turns on stage enables 0..g of a band (bits 4b..4b+3 of `band_stage_en_o` for band b) when that band is enabled, and all four are off otherwise. `det_stage_en_o` applies the same map to the detector gain in every mode.
- R6: A `cfg_we_i` pulse loads the mask, both gain codes and the idle limit. The outputs reflect the new values from the next cycle on.
- R7: In classify mode, `activity_i` high clears the idle count. Each tick with `activity_i` low adds one. The tick that brings the count to the idle limit returns the block to detect mode, and a limit of 0 acts on the first such tick.
- R8: In classify mode, each tick without a taken result adds one to a timeout count, and a taken result clears it. The tick that brings the count to TMO_TICKS returns the block to detect mode.
- R9: Every CTX_PERIOD ticks, counted from reset in every mode, a context event sets wake cause bit 1 and `host_wake_o` and enters host mode.
- R10: A context event is dropped while a speech wake is pending or is being set in the same cycle, so at most one wake cause bit is ever set.
- R11: `host_ack_i` clears both wake causes and returns the block to detect mode. A speech result or context event in the same cycle still sets its wake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| tick_i | input | 1 | Frame strobe, one cycle wide |
| activity_i | input | 1 | Threshold detector flag |
| cls_valid_i | input | 1 | Classifier result valid |
| cls_speech_i | input | 1 | Classifier result: 1 speech, 0 non-speech |
| cls_ready_o | output | 1 | Result can be taken (classify mode) |
| host_ack_i | input | 1 | Host acknowledges the wake |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_mask_i | input | N_BANDS | Per-band enable mask |
| cfg_band_gain_i | input | 2 | Band gain code |
| cfg_det_gain_i | input | 2 | Detector preamplifier gain code |
| cfg_idle_i | input | IDLE_W | Idle limit in ticks |
| mode_o | output | 2 | Current mode |
| band_en_o | output | N_BANDS | Band power enables |
| band_stage_en_o | output | N_BANDS*N_STAGES | Amplifier stage enables, four per band |
| det_stage_en_o | output | N_STAGES | Detector preamplifier stage enables |
| host_wake_o | output | 1 | Wake request to the host |
| wake_cause_o | output | 2 | Bit 0 speech, bit 1 context check |

## Verification
The bench builds the block with 16 bands of four stages, TMO_TICKS = 6, CTX_PERIOD = 37 and a 4-bit idle limit. With these values the timeout, the idle fallback with small or zero limits, and many context events all occur within a few thousand cycles. The short context period lands many events on speech wakes that are already pending, on acknowledges and on speech results taken in the same cycle. Random phases with different activity and classifier rates move the block through every transition of the ladder.

// File: rtl/sps_pkg.sv
package sps_pkg;
  typedef enum logic [1:0] {
    M_DET  = 2'd0,
    M_CLS  = 2'd1,
    M_HOST = 2'd2
  } mode_e;
endpackage

// File: rtl/sps_ctx_timer.sv
module sps_ctx_timer #(
  parameter int PERIOD = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  output logic expire_o
);
  localparam int CW = $clog2(PERIOD + 1);
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] cnt_q;

  assign expire_o = tick_i && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt_q <= '0;
    else if (expire_o)      cnt_q <= '0;
    else if (tick_i)        cnt_q <= cnt_q + 1'b1;
  end

  // R9: the interval count never passes the period
  p_ctx_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
endmodule

// File: rtl/sps_ladder_fsm.sv
module sps_ladder_fsm
  import sps_pkg::*;
#(
  parameter int TMO_TICKS = 16,
  parameter int IDLE_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              activity_i,
  input  logic              cls_valid_i,
  input  logic              cls_speech_i,
  input  logic              host_ack_i,
  input  logic              ctx_expire_i,
  input  logic [IDLE_W-1:0] idle_lim_i,
  output mode_e             mode_o,
  output logic              cls_ready_o,
  output logic              wk_speech_o,
  output logic              wk_ctx_o
);
  localparam int TW = $clog2(TMO_TICKS + 1);
  localparam logic [TW:0] TMO_L = (TW + 1)'(TMO_TICKS);

  mode_e             mode_q, mode_d;
  logic              wks_q, wks_d, wkc_q, wkc_d;
  logic [IDLE_W-1:0] idle_q, idle_d;
  logic [TW-1:0]     tmo_q, tmo_d;
  logic              take, new_s, new_c, idle_hit, tmo_hit, stay_cls;
  logic [IDLE_W:0]   idle_sum;
  logic [TW:0]       tmo_sum;

  always_comb begin
    take     = cls_valid_i && (mode_q == M_CLS);
    new_s    = take && cls_speech_i;
    new_c    = ctx_expire_i && !wks_q && !new_s;
    wks_d    = (wks_q && !host_ack_i) || new_s;
    wkc_d    = (wkc_q && !host_ack_i) || new_c;
    idle_sum = {1'b0, idle_q} + 1'b1;
    tmo_sum  = {1'b0, tmo_q} + 1'b1;
    idle_hit = tick_i && !activity_i && (idle_sum >= {1'b0, idle_lim_i});
    tmo_hit  = tick_i && !take && (tmo_sum >= TMO_L);

    mode_d = mode_q;
    if (wks_d || wkc_d) begin
      mode_d = M_HOST;
    end else begin
      unique case (mode_q)
        M_DET:   if (activity_i) mode_d = M_CLS;
        M_CLS:   if (idle_hit || tmo_hit) mode_d = M_DET;
        M_HOST:  mode_d = M_DET;
        default: mode_d = M_DET;
      endcase
    end

    stay_cls = (mode_q == M_CLS) && (mode_d == M_CLS);
    if (!stay_cls || activity_i) idle_d = '0;
    else if (tick_i)             idle_d = idle_sum[IDLE_W-1:0];
    else                         idle_d = idle_q;
    if (!stay_cls || take)       tmo_d = '0;
    else if (tick_i)             tmo_d = tmo_sum[TW-1:0];
    else                         tmo_d = tmo_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= M_DET;
      wks_q  <= 1'b0;
      wkc_q  <= 1'b0;
      idle_q <= '0;
      tmo_q  <= '0;
    end else begin
      mode_q <= mode_d;
      wks_q  <= wks_d;
      wkc_q  <= wkc_d;
      idle_q <= idle_d;
      tmo_q  <= tmo_d;
    end
  end

  assign mode_o      = mode_q;
  assign cls_ready_o = (mode_q == M_CLS);
  assign wk_speech_o = wks_q;
  assign wk_ctx_o    = wkc_q;

  // R2: classify is entered from detect only after activity was seen
  p_enter_cls_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode_q) == M_DET && mode_q == M_CLS) |-> $past(activity_i));
  // R4: a speech wake only follows a taken speech result
  p_speech_wake_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wks_q) |-> $past(cls_valid_i && cls_speech_i && mode_q == M_CLS));
  // R4: a taken non-speech result raises no wake
  p_nonspeech_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cls_valid_i && cls_ready_o && !cls_speech_i && !ctx_expire_i) |=> !(wks_q || wkc_q));
  // R8: the timeout count stays below its limit
  p_tmo_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, tmo_q} < TMO_L);
  // R10: a context event is dropped while a speech wake is pending
  p_ctx_masked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wks_q && !wkc_q && ctx_expire_i) |=> !wkc_q);
  // R11: an acknowledge with no new event leaves host mode
  p_ack_leaves_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_HOST && host_ack_i && !ctx_expire_i) |=> mode_q == M_DET);
endmodule

// File: rtl/sps_gain_map.sv
module sps_gain_map #(
  parameter int N_BANDS  = 16,
  parameter int N_STAGES = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          bands_on_i,
  input  logic [N_BANDS-1:0]            mask_i,
  input  logic [$clog2(N_STAGES)-1:0]   band_gain_i,
  input  logic [$clog2(N_STAGES)-1:0]   det_gain_i,
  output logic [N_BANDS-1:0]            band_en_o,
  output logic [N_BANDS*N_STAGES-1:0]   band_stage_o,
  output logic [N_STAGES-1:0]           det_stage_o
);
  localparam int GW = $clog2(N_STAGES);

  function automatic logic [N_STAGES-1:0] therm(input logic [GW-1:0] g);
    logic [N_STAGES-1:0] t;
    for (int i = 0; i < N_STAGES; i++) t[i] = (GW'(i) <= g);
    return t;
  endfunction

  logic [N_STAGES-1:0] band_therm;

  assign band_therm  = therm(band_gain_i);
  assign det_stage_o = therm(det_gain_i);
  assign band_en_o   = bands_on_i ? mask_i : '0;

  for (genvar b = 0; b < N_BANDS; b++) begin : g_band
    assign band_stage_o[b*N_STAGES +: N_STAGES] = band_en_o[b] ? band_therm : '0;
  end

  // R5: detector stages form a thermometer with the first stage always on
  p_det_therm_r5: assert property (@(posedge clk) disable iff (!rst_n)
    det_stage_o[0] && (((det_stage_o >> 1) & ~det_stage_o) == '0));
  // R5: the stage count of band 0 follows its gain code whenever it is on
  p_band0_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
    band_en_o[0] |-> ($countones(band_stage_o[N_STAGES-1:0]) == int'(band_gain_i) + 1));
endmodule

// File: rtl/sense_power_seq.sv
module sense_power_seq
  import sps_pkg::*;
#(
  parameter int N_BANDS    = 16,
  parameter int N_STAGES   = 4,
  parameter int IDLE_W     = 8,
  parameter int IDLE_RST   = 4,
  parameter int TMO_TICKS  = 16,
  parameter int CTX_PERIOD = 64
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          tick_i,
  input  logic                          activity_i,
  input  logic                          cls_valid_i,
  input  logic                          cls_speech_i,
  output logic                          cls_ready_o,
  input  logic                          host_ack_i,
  input  logic                          cfg_we_i,
  input  logic [N_BANDS-1:0]            cfg_mask_i,
  input  logic [$clog2(N_STAGES)-1:0]   cfg_band_gain_i,
  input  logic [$clog2(N_STAGES)-1:0]   cfg_det_gain_i,
  input  logic [IDLE_W-1:0]             cfg_idle_i,
  output logic [1:0]                    mode_o,
  output logic [N_BANDS-1:0]            band_en_o,
  output logic [N_BANDS*N_STAGES-1:0]   band_stage_en_o,
  output logic [N_STAGES-1:0]           det_stage_en_o,
  output logic                          host_wake_o,
  output logic [1:0]                    wake_cause_o
);
  localparam int GW = $clog2(N_STAGES);
  localparam logic [GW-1:0] GAIN_RST = GW'(N_STAGES - 2);

  logic [N_BANDS-1:0] mask_q;
  logic [GW-1:0]      bgain_q, dgain_q;
  logic [IDLE_W-1:0]  idle_q;
  logic               ctx_expire, wks, wkc;
  mode_e              mode;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q  <= '1;
      bgain_q <= GAIN_RST;
      dgain_q <= GAIN_RST;
      idle_q  <= IDLE_W'(IDLE_RST);
    end else if (cfg_we_i) begin
      mask_q  <= cfg_mask_i;
      bgain_q <= cfg_band_gain_i;
      dgain_q <= cfg_det_gain_i;
      idle_q  <= cfg_idle_i;
    end
  end

  sps_ctx_timer #(.PERIOD(CTX_PERIOD)) u_ctx (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .expire_o(ctx_expire)
  );

  sps_ladder_fsm #(.TMO_TICKS(TMO_TICKS), .IDLE_W(IDLE_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .activity_i(activity_i),
    .cls_valid_i(cls_valid_i), .cls_speech_i(cls_speech_i),
    .host_ack_i(host_ack_i), .ctx_expire_i(ctx_expire), .idle_lim_i(idle_q),
    .mode_o(mode), .cls_ready_o(cls_ready_o),
    .wk_speech_o(wks), .wk_ctx_o(wkc)
  );

  sps_gain_map #(.N_BANDS(N_BANDS), .N_STAGES(N_STAGES)) u_gain (
    .clk(clk), .rst_n(rst_n), .bands_on_i(mode != M_DET), .mask_i(mask_q),
    .band_gain_i(bgain_q), .det_gain_i(dgain_q),
    .band_en_o(band_en_o), .band_stage_o(band_stage_en_o),
    .det_stage_o(det_stage_en_o)
  );

  assign mode_o       = mode;
  assign host_wake_o  = wks | wkc;
  assign wake_cause_o = {wkc, wks};

  // R2: no band draws power while only the detector is on
  p_dark_in_detect_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd0) |-> (band_en_o == '0 && band_stage_en_o == '0));
  // R10: at most one wake cause is ever set
  p_cause_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wake_cause_o));
  // R11: host mode is held exactly while a wake is pending
  p_host_means_wake_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd2) == host_wake_o);
endmodule

// File: tb/sense_power_seq_tb_top.sv
module sense_power_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 16, NS = 4, IW = 4, IDLE_RST = 4, TMO = 6, CTX = 37;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 0, act = 0, cv = 0, csp = 0, ack = 0, we = 0;
  logic [NB-1:0] cmask = '0;
  logic [1:0] cbg = '0, cdg = '0;
  logic [IW-1:0] cidle = '0;
  logic cls_ready, host_wake;
  logic [1:0] mode, cause;
  logic [NB-1:0] band_en;
  logic [NB*NS-1:0] band_stage;
  logic [NS-1:0] det_stage;

  int n_run = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sense_power_seq #(.N_BANDS(NB), .N_STAGES(NS), .IDLE_W(IW), .IDLE_RST(IDLE_RST),
                    .TMO_TICKS(TMO), .CTX_PERIOD(CTX)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .activity_i(act),
    .cls_valid_i(cv), .cls_speech_i(csp), .cls_ready_o(cls_ready),
    .host_ack_i(ack), .cfg_we_i(we), .cfg_mask_i(cmask),
    .cfg_band_gain_i(cbg), .cfg_det_gain_i(cdg), .cfg_idle_i(cidle),
    .mode_o(mode), .band_en_o(band_en), .band_stage_en_o(band_stage),
    .det_stage_en_o(det_stage), .host_wake_o(host_wake), .wake_cause_o(cause)
  );

  // reference model state, built from the requirements
  int m_mode, m_idle, m_tmo, m_ctx, m_ilim;
  bit m_wks, m_wkc;
  logic [NB-1:0] m_mask;
  int m_bg, m_dg;

  function automatic logic [NS-1:0] therm_exp(int g);
    return NS'((1 << (g + 1)) - 1);
  endfunction

  function automatic logic [NB*NS-1:0] stages_exp(logic [NB-1:0] en, int g);
    logic [NB*NS-1:0] r = '0;
    for (int b = 0; b < NB; b++) if (en[b]) r[b*NS +: NS] = therm_exp(g);
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_idle = 0; m_tmo = 0; m_ctx = 0; m_wks = 0; m_wkc = 0;
      m_mask = '1; m_bg = 2; m_dg = 2; m_ilim = IDLE_RST;
    end else begin
      bit expire, take, ns, nc, ih, th, stay;
      int nm;
      expire = tick && (m_ctx + 1 == CTX);                 // R9
      if (tick) m_ctx = expire ? 0 : m_ctx + 1;
      take = cv && (m_mode == 1);                           // R3
      ns = take && csp;                                     // R4
      nc = expire && !m_wks && !ns;                         // R10
      m_wks = (m_wks && !ack) || ns;                        // R11
      m_wkc = (m_wkc && !ack) || nc;
      ih = tick && !act && (m_idle + 1 >= m_ilim);          // R7
      th = tick && !take && (m_tmo + 1 >= TMO);             // R8
      nm = m_mode;
      if (m_wks || m_wkc) nm = 2;
      else if (m_mode == 0) nm = act ? 1 : 0;
      else if (m_mode == 1) nm = (ih || th) ? 0 : 1;
      else nm = 0;
      stay = (m_mode == 1) && (nm == 1);
      m_idle = (!stay || act) ? 0 : (tick ? m_idle + 1 : m_idle);
      m_tmo  = (!stay || take) ? 0 : (tick ? m_tmo + 1 : m_tmo);
      m_mode = nm;
      if (we) begin                                         // R6
        m_mask = cmask; m_bg = cbg; m_dg = cdg; m_ilim = cidle;
      end
    end
  end

  task automatic chk(string req, logic [NB*NS-1:0] got, logic [NB*NS-1:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic check_all();
    logic [NB-1:0] en = (m_mode != 0) ? m_mask : '0;
    chk("R2 mode", 64'(mode), 64'(m_mode));
    chk("R2 band_en", 64'(band_en), 64'(en));
    chk("R5 band stages", band_stage, stages_exp(en, m_bg));
    chk("R5 det stages", 64'(det_stage), 64'(therm_exp(m_dg)));
    chk("R3 ready", 64'(cls_ready), 64'(m_mode == 1));
    chk("R11 wake", 64'(host_wake), 64'(m_wks || m_wkc));
    chk("R10 cause", 64'(cause), 64'({m_wkc, m_wks}));
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
    check_all();
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got hang expected finish");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    chk("R1 mode", 64'(mode), 64'd0);
    chk("R1 band_en", 64'(band_en), 64'd0);
    chk("R1 stages", band_stage, '0);
    chk("R1 det gain code 2", 64'(det_stage), 64'h7);
    chk("R1 wake", 64'(host_wake), 64'd0);
    chk("R1 ready", 64'(cls_ready), 64'd0);
    // R1: mask all ones and band gain 2 after wakeup of the bands
    act = 1; step(); act = 0;
    chk("R1 mask", 64'(band_en), 64'(16'hFFFF));
    chk("R1 band gain", 64'(band_stage[3:0]), 64'h7);
    // R5 and R6: each gain code, fixed pattern checks
    for (int g = 0; g < 4; g++) begin
      we = 1; cmask = 16'hA5A5; cbg = 2'(g); cdg = 2'(3 - g); cidle = 4'd9;
      step(); we = 0;
      chk("R6 mask load", 64'(band_en), 64'(16'hA5A5));
      chk("R5 band0 therm", 64'(band_stage[3:0]), 64'((1 << (g + 1)) - 1));
      chk("R5 band1 off", 64'(band_stage[7:4]), 64'd0);
      chk("R5 det therm", 64'(det_stage), 64'((1 << (4 - g)) - 1));
    end
    // R8: directed timeout, activity held high so idle never expires
    act = 1;
    for (int i = 0; i < 40; i++) begin tick = (i % 2 == 0); step(); end
    tick = 0; act = 0;
    // R3: valid in detect mode is ignored
    for (int i = 0; i < 4; i++) begin cv = 1; csp = 1; step(); end
    cv = 0; csp = 0;
    // random phases: activity %, valid 1-in-N (0 = none), idle limit
    for (int ph = 0; ph < 4; ph++) begin
      int apct = (ph == 0) ? 60 : (ph == 1) ? 15 : (ph == 2) ? 90 : 40;
      int vr   = (ph == 2) ? 0 : (ph == 1) ? 4 : 9;
      for (int c = 0; c < 1500; c++) begin
        act  = ($urandom % 100) < apct;
        tick = ($urandom % 3) == 0;
        cv   = (vr != 0) && (($urandom % vr) == 0);
        csp  = ($urandom % 4) == 0;
        ack  = host_wake ? (($urandom % 6) == 0) : (($urandom % 25) == 0);
        we   = ($urandom % 70) == 0;
        cmask = 16'($urandom); cbg = 2'($urandom); cdg = 2'($urandom);
        cidle = 4'($urandom % 6);
        step();
      end
    end
    act = 0; tick = 0; cv = 0; ack = 0; we = 0;
    step();
    summary();
    $finish;
  end
endmodule